// File: doc/BRIEF.md
# Audio Clock Ratio Speed Detector

This block sits in the clock-slave path of an audio converter. The master clock and the left/right (frame) clock come from outside. The block has to work out whether the link runs at single, double or quad speed. It also decides whether the internal master-clock divider halves the incoming master clock. Both clocks are sampled in a free-running reference clock domain. Every frame, two counts are taken: the master-clock rising edges and the reference cycles.

The edge count gives the clock ratio. Some ratios belong to two speed modes (256x and 128x). For those, the frame period measured in reference cycles picks the mode. The same period also catches sample rates above what the chosen mode can carry.

A two-bit mode input selects between this automatic slave detection and three forced clock-master settings. When a master setting is selected, the detector's result is bypassed.

Top module: `audio_rate_detect`

## Requirements
- R1: While `rst_n` is low, `speed_mode` is 00, and `mclk_div2`, `locked` and `unsupported` are 0.
- R2: `mode_pins` 00, 01 and 10 select clock-master single, double and quad speed. In these settings `speed_mode` equals `mode_pins`, `locked` is 1, and `mclk_div2` and `unsupported` are 0. `mode_pins` 11 selects slave detection. `speed_mode` never shows 11.
- R3: In slave mode, the master-clock rising edges are counted between successive frame-clock rising edges. The partial period after start is discarded. `locked` rises only when two consecutive counts differ by at most 2.
- R4: A count is taken as one of the ratios 64, 128, 256 or 512 when it lies within ±2 of it. Any other stable count gives `locked`=1 and `unsupported`=1.
- R5: A 512x ratio gives single speed (`speed_mode` 00) with `mclk_div2`=1.
- R6: A 256x ratio gives double speed (01) with `mclk_div2`=1 when the frame period is shorter than REF_HZ/75000 reference cycles, that is, a rate above 75 kHz. Otherwise it gives single speed (00) with `mclk_div2`=0.
- R7: A 128x ratio gives quad speed (10) with `mclk_div2`=1 above 150 kHz. Otherwise it gives double speed (01) with `mclk_div2`=0.
- R8: A 64x ratio is flagged `unsupported` in slave mode.
- R9: A rate above the ceiling of the chosen mode is flagged `unsupported`. The ceilings are 50 kHz for single, 100 kHz for double and 200 kHz for quad speed.
- R10: While `unsupported` is 1, `speed_mode` is 00 and `mclk_div2` is 0.
- R11: A count that differs by more than 2 from the previous count drops `locked` and returns the outputs to the R1 values. Lock returns at the next matching period.
- R12: If no frame-clock rising edge is seen for more than 1024 master-clock rising edges, `locked` drops, the outputs return to the R1 values, and detection restarts from the discard step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_in | input | 1 | External master clock, sampled in `clk_ref` domain |
| lrck_in | input | 1 | External frame clock, sampled in `clk_ref` domain |
| mode_pins | input | 2 | 00/01/10 master single/double/quad, 11 slave detect |
| speed_mode | output | 2 | 00 single, 01 double, 10 quad |
| mclk_div2 | output | 1 | Internal divider halves the master clock |
| locked | output | 1 | Ratio stable and measured |
| unsupported | output | 1 | Stable ratio or rate cannot be served |

## Verification
The four nominal ratios are each driven at two master-clock speeds. For 256x and 128x, this shows that the frame period alone decides between the two candidate modes. Ratios two off nominal and four off nominal check the edge of the tolerance window. Fast clocks at 256x and 128x push the rate past the mode ceiling, which separates "mode chosen" from "mode usable".

A switch of ratio right after a frame edge checks both the unlock and the two-period relock. A frozen frame clock checks the timeout and the restart. Forced master settings are checked against the slave result they must override.

// File: rtl/audio_rate_detect.sv
module audio_rate_detect #(
  parameter int REF_HZ        = 125_000_000,
  parameter int STOP_LIMIT    = 1024,
  parameter int TOL           = 2,
  parameter int BASE_RATIO    = 64,
  parameter int MIN_HZ        = 1_000,
  parameter int DBL_SPLIT_HZ  = 75_000,
  parameter int QUAD_SPLIT_HZ = 150_000,
  parameter int SGL_MAX_HZ    = 50_000,
  parameter int DBL_MAX_HZ    = 100_000,
  parameter int QUAD_MAX_HZ   = 200_000
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       mclk_in,
  input  logic       lrck_in,
  input  logic [1:0] mode_pins,
  output logic [1:0] speed_mode,
  output logic       mclk_div2,
  output logic       locked,
  output logic       unsupported
);

  localparam int MW           = $clog2(STOP_LIMIT + 2);
  localparam int PMAX         = REF_HZ / MIN_HZ;
  localparam int PW           = $clog2(PMAX + 1);
  localparam int R128         = BASE_RATIO * 2;
  localparam int R256         = BASE_RATIO * 4;
  localparam int R512         = BASE_RATIO * 8;
  localparam int P_DBL_SPLIT  = REF_HZ / DBL_SPLIT_HZ;
  localparam int P_QUAD_SPLIT = REF_HZ / QUAD_SPLIT_HZ;
  localparam int P_SGL_MIN    = REF_HZ / SGL_MAX_HZ;
  localparam int P_DBL_MIN    = REF_HZ / DBL_MAX_HZ;
  localparam int P_QUAD_MIN   = REF_HZ / QUAD_MAX_HZ;
  localparam logic [MW-1:0] STOP_VAL = MW'(STOP_LIMIT + 1);
  localparam logic [PW-1:0] PSAT     = PW'(PMAX);

  localparam logic [1:0] SP_SGL  = 2'b00;
  localparam logic [1:0] SP_DBL  = 2'b01;
  localparam logic [1:0] SP_QUAD = 2'b10;

  logic [2:0]    mclk_sh, lrck_sh;
  logic [1:0]    mode_q;
  logic [MW-1:0] mcnt, prev_cnt;
  logic [PW-1:0] rcnt;
  logic          armed, have_prev;
  logic          s_locked, s_unsup, s_div2;
  logic [1:0]    s_speed;

  logic          c_bad, c_div2;
  logic [1:0]    c_speed;

  wire mclk_rise = mclk_sh[1] & ~mclk_sh[2];
  wire lrck_rise = lrck_sh[1] & ~lrck_sh[2];
  wire stop      = (mcnt == STOP_VAL);
  wire slave     = (mode_q == 2'b11);
  wire [MW-1:0] cnt_now = mcnt + MW'(mclk_rise);

  function automatic logic near(input int a, input int b);
    return (a <= b + TOL) && (a + TOL >= b);
  endfunction

  wire match = have_prev && near(int'(cnt_now), int'(prev_cnt));

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      mclk_sh <= '0;
      lrck_sh <= '0;
      mode_q  <= 2'b11;
    end else begin
      mclk_sh <= {mclk_sh[1:0], mclk_in};
      lrck_sh <= {lrck_sh[1:0], lrck_in};
      mode_q  <= mode_pins;
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      mcnt <= '0;
      rcnt <= '0;
    end else begin
      if (lrck_rise)   mcnt <= '0;
      else if (!stop)  mcnt <= cnt_now;
      if (lrck_rise)          rcnt <= PW'(1);
      else if (rcnt != PSAT)  rcnt <= rcnt + PW'(1);
    end
  end

  always_comb begin
    c_speed = SP_SGL;
    c_div2  = 1'b0;
    c_bad   = 1'b1;
    if (near(int'(cnt_now), R512)) begin
      c_speed = SP_SGL;
      c_div2  = 1'b1;
      c_bad   = int'(rcnt) < P_SGL_MIN;
    end else if (near(int'(cnt_now), R256)) begin
      if (int'(rcnt) < P_DBL_SPLIT) begin
        c_speed = SP_DBL;
        c_div2  = 1'b1;
        c_bad   = int'(rcnt) < P_DBL_MIN;
      end else begin
        c_speed = SP_SGL;
        c_div2  = 1'b0;
        c_bad   = int'(rcnt) < P_SGL_MIN;
      end
    end else if (near(int'(cnt_now), R128)) begin
      if (int'(rcnt) < P_QUAD_SPLIT) begin
        c_speed = SP_QUAD;
        c_div2  = 1'b1;
        c_bad   = int'(rcnt) < P_QUAD_MIN;
      end else begin
        c_speed = SP_DBL;
        c_div2  = 1'b0;
        c_bad   = int'(rcnt) < P_DBL_MIN;
      end
    end
    if (c_bad) begin
      c_speed = SP_SGL;
      c_div2  = 1'b0;
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      have_prev <= 1'b0;
      prev_cnt  <= '0;
      s_locked  <= 1'b0;
      s_unsup   <= 1'b0;
      s_div2    <= 1'b0;
      s_speed   <= SP_SGL;
    end else if (stop) begin
      armed     <= 1'b0;
      have_prev <= 1'b0;
      s_locked  <= 1'b0;
      s_unsup   <= 1'b0;
      s_div2    <= 1'b0;
      s_speed   <= SP_SGL;
    end else if (lrck_rise) begin
      if (!armed) begin
        armed <= 1'b1;
      end else begin
        prev_cnt  <= cnt_now;
        have_prev <= 1'b1;
        s_locked  <= match;
        s_unsup   <= match & c_bad;
        s_div2    <= match & c_div2;
        s_speed   <= match ? c_speed : SP_SGL;
      end
    end
  end

  assign speed_mode  = slave ? s_speed : mode_q;
  assign mclk_div2   = slave & s_div2;
  assign locked      = slave ? s_locked : 1'b1;
  assign unsupported = slave & s_unsup;

  assert_lock_needs_edge_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(s_locked) |-> $past(lrck_rise));

  assert_stop_clears_R12: assert property (@(posedge clk_ref) disable iff (!rst_n)
    stop |=> !s_locked && !s_unsup);

  assert_unsup_defaults_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    unsupported |-> (speed_mode == SP_SGL) && !mclk_div2);

  assert_code_legal_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    speed_mode != 2'b11);

  assert_hold_between_edges_R11: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!$past(lrck_rise) && !$past(stop)) |-> ($stable(s_speed) && $stable(s_locked)));

  assert_div_needs_lock_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    s_div2 |-> s_locked);

endmodule

// File: tb/audio_rate_detect_bench.sv
module audio_rate_detect_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       mclk, lrck;
  logic [1:0] mode_pins = 2'b11;
  logic [1:0] speed_mode;
  logic       mclk_div2, locked, unsupported;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int gen_ratio = 256;
  int gen_h = 5;
  bit gen_run = 1;

  typedef struct {
    string      tag;
    logic [1:0] sp;
    logic       dv, lk, un;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  audio_rate_detect u_audio_rate_detect (
    .clk_ref(clk), .rst_n(rst_n), .mclk_in(mclk), .lrck_in(lrck),
    .mode_pins(mode_pins), .speed_mode(speed_mode), .mclk_div2(mclk_div2),
    .locked(locked), .unsupported(unsupported));

  initial begin
    int fcnt;
    mclk = 0; lrck = 0; fcnt = 0;
    forever begin
      repeat (gen_h) @(negedge clk);
      mclk = ~mclk;
      if (!mclk) begin
        fcnt++;
        if (fcnt >= gen_ratio / 2) begin
          fcnt = 0;
          if (gen_run) lrck = ~lrck;
        end
      end
    end
  end

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(posedge clk); #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (speed_mode !== e.sp || mclk_div2 !== e.dv || locked !== e.lk || unsupported !== e.un) begin
          bad++;
          $display("FAIL %s: got sp=%b div=%b lk=%b un=%b expected sp=%b div=%b lk=%b un=%b",
                   e.tag, speed_mode, mclk_div2, locked, unsupported, e.sp, e.dv, e.lk, e.un);
        end
      end
    end
  end

  task automatic expect_out(string tag, logic [1:0] sp, logic dv, logic lk, logic un);
    exp_t e;
    e.tag = tag; e.sp = sp; e.dv = dv; e.lk = lk; e.un = un;
    q.push_back(e);
    @(posedge clk); #3;
  endtask

  function automatic bit near(int a, int b);
    return (a <= b + 2) && (a + 2 >= b);
  endfunction

  // expected result from R4..R10, rate compared as period*limit vs 125 MHz
  task automatic model(int ratio, int h, output logic [1:0] sp, output logic dv, output logic un);
    longint p = longint'(ratio) * 2 * h;
    longint refhz = 125_000_000;
    bit over;
    sp = 2'b00; dv = 0; un = 1; over = 0;
    if (near(ratio, 512)) begin
      sp = 2'b00; dv = 1; over = p * 50_000 < refhz; un = 0;
    end else if (near(ratio, 256)) begin
      if (p * 75_000 < refhz) begin sp = 2'b01; dv = 1; over = p * 100_000 < refhz; end
      else begin sp = 2'b00; dv = 0; over = p * 50_000 < refhz; end
      un = 0;
    end else if (near(ratio, 128)) begin
      if (p * 150_000 < refhz) begin sp = 2'b10; dv = 1; over = p * 200_000 < refhz; end
      else begin sp = 2'b01; dv = 0; over = p * 100_000 < refhz; end
      un = 0;
    end
    if (over) un = 1;
    if (un) begin sp = 2'b00; dv = 0; end
  endtask

  task automatic slave_case(string tag, int ratio, int h);
    logic [1:0] sp; logic dv, un;
    gen_ratio = ratio; gen_h = h;
    repeat (4 * ratio * 2 * h + 40) @(posedge clk);
    model(ratio, h, sp, dv, un);
    expect_out(tag, sp, dv, 1'b1, un);
  endtask

  initial begin
    repeat (3) @(posedge clk); #3;
    expect_out("R1 reset defaults", 2'b00, 0, 0, 0);
    rst_n = 1;

    slave_case("R6 256x 48.8kHz single", 256, 5);
    slave_case("R5 512x 40.7kHz single div2", 512, 3);
    slave_case("R6 256x 81kHz double", 256, 3);
    slave_case("R7 128x 97.6kHz double", 128, 5);
    slave_case("R7 128x 163kHz quad", 128, 3);
    slave_case("R8 64x in slave unsupported", 64, 5);
    slave_case("R9 256x 61kHz over single ceiling", 256, 4);
    slave_case("R9 R10 128x 244kHz over quad ceiling", 128, 2);
    slave_case("R4 258 within tolerance", 258, 5);
    slave_case("R4 260 outside tolerance", 260, 5);

    slave_case("R6 back to 256x", 256, 5);
    gen_run = 0;
    repeat (11_000) @(posedge clk);
    expect_out("R12 frame clock stopped", 2'b00, 0, 0, 0);
    gen_run = 1;
    repeat (4 * 256 * 10 + 40) @(posedge clk);
    expect_out("R12 restart relock", 2'b00, 0, 1, 0);

    @(posedge lrck);
    gen_ratio = 128;
    @(posedge lrck);
    repeat (20) @(posedge clk);
    expect_out("R11 ratio change unlock", 2'b00, 0, 0, 0);
    @(posedge lrck);
    repeat (20) @(posedge clk);
    expect_out("R3 R11 relock after two equal periods", 2'b01, 0, 1, 0);

    mode_pins = 2'b01;
    repeat (4) @(posedge clk);
    expect_out("R2 master double", 2'b01, 0, 1, 0);
    mode_pins = 2'b10;
    repeat (4) @(posedge clk);
    expect_out("R2 master quad", 2'b10, 0, 1, 0);
    mode_pins = 2'b00;
    repeat (4) @(posedge clk);
    expect_out("R2 master single", 2'b00, 0, 1, 0);
    mode_pins = 2'b11;
    repeat (4) @(posedge clk);
    expect_out("R2 back to slave result", 2'b01, 0, 1, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule